// File: doc/BRIEF.md
# Hybrid Coherence Directory Controller

This block is the directory side of a write-through coherence scheme covering a small set of cache lines. For every line it keeps a precise list of sharer copies. Each entry records the requester ID of a first-level cache and whether that copy sits in the instruction cache or the data cache. While the number of copies stays at or below a threshold, a write produces one update packet for each registered copy except the writer's own. An eviction produces one invalidate packet for each copy. If a new copy would push the count above the threshold, the line drops its list and keeps only a copy counter. From then on, a write or an eviction produces a single broadcast invalidate, and the counter goes down by one for each cleanup that comes back.

Memory always holds the newest data, so there is no exclusive or owned state. The directory only tracks copies and sequences coherence traffic. Requests arrive on a valid/ready port. A read registers a copy; a write or an eviction starts a coherence transaction. Cleanups and update acknowledgements come in on their own inputs. Coherence packets, cleanup acknowledgements and a completion pulse go out.

A single transaction controller runs through these states:
- `ST_IDLE`: takes a request.
- `ST_MCAST`: sends one addressed packet per cycle.
- `ST_BCAST`: sends the single broadcast.
- `ST_WAIT`: counts acknowledgements or waits for the line's copy count to reach zero.
- `ST_DONE`: one-cycle completion pulse.

Its transitions are:
- IDLE→MCAST: list-mode write or eviction with at least one target.
- IDLE→BCAST: any write or eviction on a line in count mode.
- IDLE→DONE: list-mode write or eviction with no target.
- MCAST→WAIT: last target sent.
- BCAST→WAIT: always, after one cycle.
- WAIT→DONE: completion condition met.
- DONE→IDLE: always.

Top module: `hc_dir`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1 and `coh_valid`, `done_valid` and `clack_valid` are 0.
- R2: A read request (`req_op`=0) registers the pair (`req_id`, `req_instr`) once per line. A repeated pair adds nothing. The instruction copy (`req_instr`=1) and the data copy (`req_instr`=0) of one ID are separate entries.
- R3: A write (`req_op`=1) to a line in list mode sends one packet per registered pair except the pair equal to (`req_id`, `req_instr`) of the writer. Each packet has `coh_kind`=0 (update) and carries the line, the ID and the instruction flag. The packets go out on consecutive cycles, starting the cycle after acceptance.
- R4: A list-mode write completes only after it has received as many `uack_valid` pulses on its line as it sent updates. `done_valid` pulses for one cycle with `done_op`=1 and the line, in the second cycle after the last acknowledgement is sampled. With no targets, the pulse comes the cycle after acceptance.
- R5: A registration that would take a line's copy count above `THRESH` switches the line to count mode. Later registrations add to the counter. The next write or eviction (`req_op`=2) then sends exactly one packet with `coh_kind`=2 (broadcast), the cycle after acceptance.
- R6: In count mode each cleanup on the line lowers the counter by one. The write or eviction completes in the second cycle after the cleanup that brings the counter to zero, and never before. The line then returns to list mode with no entries.
- R7: An eviction of a list-mode line sends one packet with `coh_kind`=1 (invalidate) to every registered pair. It completes with `done_op`=2, in the second cycle after the cleanup that removes the last entry.
- R8: Every cleanup is answered in the next cycle by a one-cycle `clack_valid` that echoes its line, ID and instruction flag.
- R9: A cleanup whose pair is not registered on the line is acknowledged and leaves the line's list unchanged.
- R10: From the acceptance of a write or an eviction until the cycle after its completion pulse, `req_ready` is 0 for every request, and held requests start nothing.
- R11: Registrations and transactions on one line have no effect on the sharers of another line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 2 | 0 read/register, 1 write, 2 evict, 3 no effect |
| req_line | input | LINE_W | Line index |
| req_id | input | ID_W | Requester ID |
| req_instr | input | 1 | 1 = instruction copy, 0 = data copy |
| cln_valid | input | 1 | Cleanup received |
| cln_line | input | LINE_W | Cleanup line |
| cln_id | input | ID_W | Cleanup requester ID |
| cln_instr | input | 1 | Cleanup copy type |
| uack_valid | input | 1 | Update acknowledgement received |
| uack_line | input | LINE_W | Acknowledged line |
| coh_valid | output | 1 | Coherence packet out |
| coh_kind | output | 2 | 0 update, 1 invalidate, 2 broadcast |
| coh_line | output | LINE_W | Packet line |
| coh_id | output | ID_W | Target ID (0 for broadcast) |
| coh_instr | output | 1 | Target copy type |
| clack_valid | output | 1 | Cleanup acknowledge out |
| clack_line | output | LINE_W | Acknowledged line |
| clack_id | output | ID_W | Destination ID |
| clack_instr | output | 1 | Destination copy type |
| done_valid | output | 1 | Transaction complete pulse |
| done_op | output | 2 | Completed operation (1 write, 2 evict) |
| done_line | output | LINE_W | Completed line |

## Verification
Every result has a fixed due cycle measured from the sampled input:
- The first coherence packet appears the cycle after acceptance, and the rest follow one per cycle.
- A cleanup acknowledgement appears the cycle after its cleanup.
- The completion pulse comes two cycles after the finishing acknowledgement or cleanup, or one cycle after acceptance when there is no target.

The bench drives and samples on the falling edge. It checks each output exactly at its due cycle, checks that `done_valid` is still low in the cycle before it, and checks that it is low again the cycle after. It sweeps every line and every list size from zero to the threshold.

// File: rtl/hc_dir_pkg.sv
package hc_dir_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_EVICT = 2'd2,
        OP_NOP   = 2'd3
    } req_op_e;

    typedef enum logic [1:0] {
        PK_UPDATE = 2'd0,
        PK_INVAL  = 2'd1,
        PK_BCAST  = 2'd2,
        PK_NONE   = 2'd3
    } pkt_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_MCAST = 3'd1,
        ST_BCAST = 3'd2,
        ST_WAIT  = 3'd3,
        ST_DONE  = 3'd4
    } txn_state_e;
endpackage

// File: rtl/hc_dir_line.sv
module hc_dir_line #(
    parameter int ID_W   = 4,
    parameter int THRESH = 4,
    parameter int CNT_W  = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         add_en,
    input  logic [ID_W-1:0]              add_id,
    input  logic                         add_instr,
    input  logic                         cln_en,
    input  logic [ID_W-1:0]              cln_id,
    input  logic                         cln_instr,
    output logic [THRESH-1:0]            ent_valid,
    output logic [THRESH-1:0][ID_W-1:0]  ent_id,
    output logic [THRESH-1:0]            ent_instr,
    output logic [CNT_W-1:0]             cnt,
    output logic                         bcast_mode
);
    localparam int IDX_W = (THRESH > 1) ? $clog2(THRESH) : 1;

    logic             add_hit;
    logic             cln_hit;
    logic             free_found;
    logic [IDX_W-1:0] cln_idx;
    logic [IDX_W-1:0] free_idx;

    // Lookup: lowest matching / lowest free slot wins.
    always_comb begin
        add_hit    = 1'b0;
        cln_hit    = 1'b0;
        free_found = 1'b0;
        cln_idx    = '0;
        free_idx   = '0;
        for (int i = THRESH - 1; i >= 0; i--) begin
            if (ent_valid[i] && ent_id[i] == add_id && ent_instr[i] == add_instr)
                add_hit = 1'b1;
            if (ent_valid[i] && ent_id[i] == cln_id && ent_instr[i] == cln_instr) begin
                cln_hit = 1'b1;
                cln_idx = IDX_W'(i);
            end
            if (!ent_valid[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid  <= '0;
            ent_id     <= '0;
            ent_instr  <= '0;
            cnt        <= '0;
            bcast_mode <= 1'b0;
        end else if (add_en) begin
            if (bcast_mode) begin
                if (cnt != '1)
                    cnt <= cnt + CNT_W'(1);
            end else if (!add_hit) begin
                if (free_found) begin
                    ent_valid[free_idx] <= 1'b1;
                    ent_id[free_idx]    <= add_id;
                    ent_instr[free_idx] <= add_instr;
                    cnt                 <= cnt + CNT_W'(1);
                end else begin
                    // List full: fall back to counting copies only.
                    bcast_mode <= 1'b1;
                    ent_valid  <= '0;
                    cnt        <= cnt + CNT_W'(1);
                end
            end
        end else if (cln_en) begin
            if (bcast_mode) begin
                if (cnt != '0)
                    cnt <= cnt - CNT_W'(1);
                if (cnt <= CNT_W'(1))
                    bcast_mode <= 1'b0;
            end else if (cln_hit) begin
                ent_valid[cln_idx] <= 1'b0;
                cnt                <= cnt - CNT_W'(1);
            end
        end
    end

    // R2
    list_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bcast_mode |-> (cnt == CNT_W'($countones(ent_valid))));

    // R6
    bcast_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bcast_mode |-> (cnt != '0));
endmodule

// File: rtl/hc_dir_txn.sv
module hc_dir_txn
    import hc_dir_pkg::*;
#(
    parameter int NLINES = 4,
    parameter int LINE_W = 2,
    parameter int ID_W   = 4,
    parameter int THRESH = 4,
    parameter int CNT_W  = 6
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    acc,
    input  logic [1:0]                              acc_op,
    input  logic [LINE_W-1:0]                       acc_line,
    input  logic [ID_W-1:0]                         acc_id,
    input  logic                                    acc_instr,
    input  logic [NLINES-1:0][THRESH-1:0]           all_valid,
    input  logic [NLINES-1:0][THRESH-1:0][ID_W-1:0] all_id,
    input  logic [NLINES-1:0][THRESH-1:0]           all_instr,
    input  logic [NLINES-1:0][CNT_W-1:0]            all_cnt,
    input  logic [NLINES-1:0]                       all_bmode,
    input  logic                                    uack_valid,
    input  logic [LINE_W-1:0]                       uack_line,
    output logic                                    idle,
    output logic                                    coh_valid,
    output logic [1:0]                              coh_kind,
    output logic [LINE_W-1:0]                       coh_line,
    output logic [ID_W-1:0]                         coh_id,
    output logic                                    coh_instr,
    output logic                                    done_valid,
    output logic [1:0]                              done_op,
    output logic [LINE_W-1:0]                       done_line
);
    localparam int IDX_W = (THRESH > 1) ? $clog2(THRESH) : 1;

    txn_state_e                  state_q;
    txn_state_e                  state_d;
    logic [LINE_W-1:0]           cur_line;
    logic [1:0]                  cur_op;
    logic [THRESH-1:0]           pend;
    logic [THRESH-1:0]           pend_clr;
    logic [THRESH-1:0][ID_W-1:0] snap_id;
    logic [THRESH-1:0]           snap_instr;
    logic [CNT_W-1:0]            need;
    logic [CNT_W-1:0]            got;
    logic                        wait_acks;
    logic [THRESH-1:0]           tmask;
    logic [IDX_W-1:0]            pk_idx;
    logic                        ack_hit;
    logic                        wait_met;

    // Target mask for an incoming write/evict: all copies, minus the writer.
    always_comb begin
        for (int i = 0; i < THRESH; i++) begin
            tmask[i] = all_valid[acc_line][i] &&
                       !(acc_op == OP_WRITE &&
                         all_id[acc_line][i] == acc_id &&
                         all_instr[acc_line][i] == acc_instr);
        end
    end

    // Lowest pending target.
    always_comb begin
        pk_idx = '0;
        for (int i = THRESH - 1; i >= 0; i--) begin
            if (pend[i])
                pk_idx = IDX_W'(i);
        end
        pend_clr         = pend;
        pend_clr[pk_idx] = 1'b0;
    end

    assign ack_hit  = uack_valid && (uack_line == cur_line) && wait_acks &&
                      (state_q == ST_MCAST || state_q == ST_WAIT);
    assign wait_met = wait_acks ? (got == need) : (all_cnt[cur_line] == '0);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acc) begin
                    if (all_bmode[acc_line])
                        state_d = ST_BCAST;
                    else if (tmask != '0)
                        state_d = ST_MCAST;
                    else
                        state_d = ST_DONE;
                end
            end
            ST_MCAST: if (pend_clr == '0) state_d = ST_WAIT;
            ST_BCAST: state_d = ST_WAIT;
            ST_WAIT:  if (wait_met) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Transaction context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_line   <= '0;
            cur_op     <= '0;
            pend       <= '0;
            snap_id    <= '0;
            snap_instr <= '0;
            need       <= '0;
            got        <= '0;
            wait_acks  <= 1'b0;
        end else if (state_q == ST_IDLE && acc) begin
            cur_line   <= acc_line;
            cur_op     <= acc_op;
            pend       <= tmask;
            snap_id    <= all_id[acc_line];
            snap_instr <= all_instr[acc_line];
            need       <= CNT_W'($countones(tmask));
            got        <= '0;
            wait_acks  <= (acc_op == OP_WRITE) && !all_bmode[acc_line];
        end else begin
            if (state_q == ST_MCAST)
                pend <= pend_clr;
            if (ack_hit)
                got <= got + CNT_W'(1);
        end
    end

    // Outputs.
    always_comb begin
        idle       = (state_q == ST_IDLE);
        coh_valid  = 1'b0;
        coh_kind   = PK_NONE;
        coh_line   = cur_line;
        coh_id     = '0;
        coh_instr  = 1'b0;
        done_valid = 1'b0;
        done_op    = cur_op;
        done_line  = cur_line;
        unique case (state_q)
            ST_MCAST: begin
                coh_valid = 1'b1;
                coh_kind  = (cur_op == OP_WRITE) ? PK_UPDATE : PK_INVAL;
                coh_id    = snap_id[pk_idx];
                coh_instr = snap_instr[pk_idx];
            end
            ST_BCAST: begin
                coh_valid = 1'b1;
                coh_kind  = PK_BCAST;
            end
            ST_DONE:  done_valid = 1'b1;
            default: ;
        endcase
    end

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    // R5
    single_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (coh_valid && coh_kind == PK_BCAST) |=> !coh_valid);
endmodule

// File: rtl/hc_dir_clack.sv
module hc_dir_clack #(
    parameter int LINE_W = 2,
    parameter int ID_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cln_valid,
    input  logic [LINE_W-1:0] cln_line,
    input  logic [ID_W-1:0]   cln_id,
    input  logic              cln_instr,
    output logic              clack_valid,
    output logic [LINE_W-1:0] clack_line,
    output logic [ID_W-1:0]   clack_id,
    output logic              clack_instr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clack_valid <= 1'b0;
            clack_line  <= '0;
            clack_id    <= '0;
            clack_instr <= 1'b0;
        end else begin
            clack_valid <= cln_valid;
            if (cln_valid) begin
                clack_line  <= cln_line;
                clack_id    <= cln_id;
                clack_instr <= cln_instr;
            end
        end
    end
endmodule

// File: rtl/hc_dir.sv
module hc_dir
    import hc_dir_pkg::*;
#(
    parameter int NLINES = 4,
    parameter int ID_W   = 4,
    parameter int THRESH = 4,
    localparam int LINE_W = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [LINE_W-1:0] req_line,
    input  logic [ID_W-1:0]   req_id,
    input  logic              req_instr,
    input  logic              cln_valid,
    input  logic [LINE_W-1:0] cln_line,
    input  logic [ID_W-1:0]   cln_id,
    input  logic              cln_instr,
    input  logic              uack_valid,
    input  logic [LINE_W-1:0] uack_line,
    output logic              coh_valid,
    output logic [1:0]        coh_kind,
    output logic [LINE_W-1:0] coh_line,
    output logic [ID_W-1:0]   coh_id,
    output logic              coh_instr,
    output logic              clack_valid,
    output logic [LINE_W-1:0] clack_line,
    output logic [ID_W-1:0]   clack_id,
    output logic              clack_instr,
    output logic              done_valid,
    output logic [1:0]        done_op,
    output logic [LINE_W-1:0] done_line
);
    localparam int CNT_A = ID_W + 2;
    localparam int CNT_B = $clog2(THRESH + 2) + 1;
    localparam int CNT_W = (CNT_A > CNT_B) ? CNT_A : CNT_B;

    logic [NLINES-1:0][THRESH-1:0]           line_valid;
    logic [NLINES-1:0][THRESH-1:0][ID_W-1:0] line_id;
    logic [NLINES-1:0][THRESH-1:0]           line_instr;
    logic [NLINES-1:0][CNT_W-1:0]            line_cnt;
    logic [NLINES-1:0]                       line_bmode;
    logic                                    txn_idle;
    logic                                    fire;
    logic                                    acc;

    // A cleanup to the same line in the same cycle holds the request back.
    assign req_ready = txn_idle && !(cln_valid && cln_line == req_line);
    assign fire      = req_valid && req_ready;
    assign acc       = fire && (req_op == OP_WRITE || req_op == OP_EVICT);

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        hc_dir_line #(
            .ID_W  (ID_W),
            .THRESH(THRESH),
            .CNT_W (CNT_W)
        ) u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .add_en    (fire && req_op == OP_READ && req_line == LINE_W'(g)),
            .add_id    (req_id),
            .add_instr (req_instr),
            .cln_en    (cln_valid && cln_line == LINE_W'(g)),
            .cln_id    (cln_id),
            .cln_instr (cln_instr),
            .ent_valid (line_valid[g]),
            .ent_id    (line_id[g]),
            .ent_instr (line_instr[g]),
            .cnt       (line_cnt[g]),
            .bcast_mode(line_bmode[g])
        );
    end

    hc_dir_txn #(
        .NLINES(NLINES),
        .LINE_W(LINE_W),
        .ID_W  (ID_W),
        .THRESH(THRESH),
        .CNT_W (CNT_W)
    ) u_txn (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .acc_op    (req_op),
        .acc_line  (req_line),
        .acc_id    (req_id),
        .acc_instr (req_instr),
        .all_valid (line_valid),
        .all_id    (line_id),
        .all_instr (line_instr),
        .all_cnt   (line_cnt),
        .all_bmode (line_bmode),
        .uack_valid(uack_valid),
        .uack_line (uack_line),
        .idle      (txn_idle),
        .coh_valid (coh_valid),
        .coh_kind  (coh_kind),
        .coh_line  (coh_line),
        .coh_id    (coh_id),
        .coh_instr (coh_instr),
        .done_valid(done_valid),
        .done_op   (done_op),
        .done_line (done_line)
    );

    hc_dir_clack #(
        .LINE_W(LINE_W),
        .ID_W  (ID_W)
    ) u_clack (
        .clk        (clk),
        .rst_n      (rst_n),
        .cln_valid  (cln_valid),
        .cln_line   (cln_line),
        .cln_id     (cln_id),
        .cln_instr  (cln_instr),
        .clack_valid(clack_valid),
        .clack_line (clack_line),
        .clack_id   (clack_id),
        .clack_instr(clack_instr)
    );

    // R10
    busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !req_ready);
endmodule

// File: tb/tb_hc_dir.sv
`timescale 1ns/1ps
module tb_hc_dir;
    localparam int NL  = 4;
    localparam int IDW = 4;
    localparam int TH  = 4;
    localparam int LW  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = '0;
    logic [LW-1:0] req_line = '0;
    logic [IDW-1:0] req_id = '0;
    logic          req_instr = 1'b0;
    logic          cln_valid = 1'b0;
    logic [LW-1:0] cln_line = '0;
    logic [IDW-1:0] cln_id = '0;
    logic          cln_instr = 1'b0;
    logic          uack_valid = 1'b0;
    logic [LW-1:0] uack_line = '0;
    logic          coh_valid;
    logic [1:0]    coh_kind;
    logic [LW-1:0] coh_line;
    logic [IDW-1:0] coh_id;
    logic          coh_instr;
    logic          clack_valid;
    logic [LW-1:0] clack_line;
    logic [IDW-1:0] clack_id;
    logic          clack_instr;
    logic          done_valid;
    logic [1:0]    done_op;
    logic [LW-1:0] done_line;

    always #5 clk = ~clk;

    hc_dir #(.NLINES(NL), .ID_W(IDW), .THRESH(TH)) dut (.*);

    int checks = 0;
    int fails  = 0;
    int n_got;
    int got_kind  [16];
    int got_id    [16];
    int got_instr [16];
    int got_line  [16];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send_req(input int op, input int line, input int id, input int ins);
        req_valid = 1'b1; req_op = 2'(op); req_line = LW'(line);
        req_id = IDW'(id); req_instr = ins[0];
        #1;
        chk(req_ready == 1'b1, "R10", "ready before request", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic collect();
        n_got = 0;
        while (coh_valid && n_got < 16) begin
            got_kind[n_got]  = int'(coh_kind);
            got_id[n_got]    = int'(coh_id);
            got_instr[n_got] = int'(coh_instr);
            got_line[n_got]  = int'(coh_line);
            n_got++;
            @(negedge clk);
        end
    endtask

    function automatic bit has_pkt(input int kind, input int line, input int id, input int ins);
        for (int i = 0; i < n_got; i++)
            if (got_kind[i] == kind && got_line[i] == line && got_id[i] == id && got_instr[i] == ins)
                return 1'b1;
        return 1'b0;
    endfunction

    task automatic cleanup(input int line, input int id, input int ins);
        cln_valid = 1'b1; cln_line = LW'(line); cln_id = IDW'(id); cln_instr = ins[0];
        @(negedge clk);
        cln_valid = 1'b0;
        // R8: acknowledge one cycle after the cleanup, echoing its fields
        chk(clack_valid && int'(clack_line) == line && int'(clack_id) == id &&
            int'(clack_instr) == ins, "R8", "clack id", int'(clack_id), id);
    endtask

    task automatic uack(input int line);
        uack_valid = 1'b1; uack_line = LW'(line);
        @(negedge clk);
        uack_valid = 1'b0;
    endtask

    // Called at the negedge right after the completing input was sampled.
    task automatic expect_done(input int op, input int line, input string req);
        chk(done_valid == 1'b0, req, "done too early", int'(done_valid), 0);
        @(negedge clk);
        chk(done_valid == 1'b1 && int'(done_op) == op && int'(done_line) == line,
            req, "done pulse op", int'(done_op), op);
        chk(req_ready == 1'b0, "R10", "ready during done", int'(req_ready), 0);
        @(negedge clk);
        chk(done_valid == 1'b0, req, "done one cycle", int'(done_valid), 0);
        chk(req_ready == 1'b1, "R10", "ready after done", int'(req_ready), 1);
    endtask

    task automatic expect_done_now(input int op, input int line, input string req);
        chk(done_valid == 1'b1 && int'(done_op) == op && int'(done_line) == line,
            req, "immediate done", int'(done_valid), 1);
        @(negedge clk);
        chk(done_valid == 1'b0 && req_ready == 1'b1, req, "after immediate done",
            int'(done_valid), 0);
    endtask

    function automatic int sid(input int k, input int line);
        return k / 2 + 1 + line;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(req_ready && !coh_valid && !done_valid && !clack_valid, "R1", "reset outputs",
            int'(coh_valid) + int'(done_valid) + int'(clack_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !coh_valid && !done_valid && !clack_valid, "R1", "after reset",
            int'(req_ready), 1);

        // Sweep: every line, every list size 0..TH
        for (int line = 0; line < NL; line++) begin
            for (int n = 0; n <= TH; n++) begin
                int wid;
                int exp;
                for (int k = 0; k < n; k++) send_req(0, line, sid(k, line), k % 2);
                // R2: duplicate registration adds nothing
                if (n > 0) send_req(0, line, sid(0, line), 0);
                // R11: a neighbouring line stays empty
                send_req(2, (line + 1) % NL, 0, 0);
                collect();
                chk(n_got == 0, "R11", "neighbour packets", n_got, 0);
                expect_done_now(2, (line + 1) % NL, "R11");

                // R3: write from sharer 0 (or from an outsider)
                wid = (n > 0) ? sid(0, line) : 12;
                exp = (n > 0) ? n - 1 : 0;
                send_req(1, line, wid, 0);
                if (exp == 0) begin
                    chk(!coh_valid, "R3", "no update", int'(coh_valid), 0);
                    expect_done_now(1, line, "R4");
                end else begin
                    chk(req_ready == 1'b0, "R10", "ready busy", int'(req_ready), 1'b0);
                    collect();
                    chk(n_got == exp, "R3", "update count", n_got, exp);
                    for (int k = 1; k < n; k++)
                        chk(has_pkt(0, line, sid(k, line), k % 2), "R3", "update target",
                            sid(k, line), sid(k, line));
                    for (int a = 0; a < exp; a++) begin
                        uack(line);
                        if (a < exp - 1)
                            chk(!done_valid, "R4", "done before last ack", int'(done_valid), 0);
                    end
                    expect_done(1, line, "R4");
                end

                // R7: evict sends inval to all, incl. writer; R2 dup check via count
                send_req(2, line, 0, 0);
                if (n == 0) begin
                    expect_done_now(2, line, "R7");
                end else begin
                    collect();
                    chk(n_got == n, "R7", "inval count", n_got, n);
                    for (int k = 0; k < n; k++)
                        chk(has_pkt(1, line, sid(k, line), k % 2), "R7", "inval target",
                            sid(k, line), sid(k, line));
                    for (int k = 0; k < n; k++) begin
                        cleanup(line, sid(k, line), k % 2);
                        if (k < n - 1)
                            chk(!done_valid, "R7", "done before last cleanup", int'(done_valid), 0);
                    end
                    expect_done(2, line, "R7");
                end
            end
        end

        // Threshold overflow: write and evict in count mode
        for (int extra = 1; extra <= 3; extra++) begin
            int tot;
            int op;
            tot = TH + extra;
            op  = (extra % 2 == 1) ? 1 : 2;
            for (int k = 0; k < tot; k++) send_req(0, 1, k + 2, 0);
            send_req(op, 1, 2, 0);
            collect();
            // R5: exactly one broadcast
            chk(n_got == 1 && got_kind[0] == 2 && got_line[0] == 1, "R5", "broadcast count",
                n_got, 1);
            for (int k = 0; k < tot; k++) begin
                cleanup(1, k + 2, 0);
                if (k < tot - 1)
                    chk(!done_valid, "R6", "done before count zero", int'(done_valid), 0);
            end
            expect_done(op, 1, "R6");
            // R6: back to list mode, empty
            send_req(0, 1, 5, 0);
            send_req(1, 1, 9, 0);
            collect();
            chk(n_got == 1 && got_kind[0] == 0 && got_id[0] == 5, "R6", "list mode again",
                n_got, 1);
            uack(1);
            expect_done(1, 1, "R6");
            send_req(2, 1, 0, 0);
            collect();
            chk(n_got == 1 && got_kind[0] == 1, "R6", "single inval", n_got, 1);
            cleanup(1, 5, 0);
            expect_done(2, 1, "R6");
        end

        // R9: cleanups from unregistered pairs
        send_req(0, 2, 3, 0);
        send_req(0, 2, 4, 1);
        cleanup(2, 3, 1);
        cleanup(2, 7, 0);
        send_req(2, 2, 0, 0);
        collect();
        chk(n_got == 2 && has_pkt(1, 2, 3, 0) && has_pkt(1, 2, 4, 1), "R9", "list unchanged",
            n_got, 2);
        cleanup(2, 3, 0);
        cleanup(2, 4, 1);
        expect_done(2, 2, "R9");

        // R10: held requests are stalled and start nothing
        send_req(0, 0, 6, 0);
        send_req(1, 0, 8, 0);
        collect();
        chk(n_got == 1, "R10", "one update", n_got, 1);
        req_valid = 1'b1; req_op = 2'd2; req_line = 2'd0;
        for (int c = 0; c < 3; c++) begin
            #1;
            chk(!req_ready && !coh_valid, "R10", "stalled", int'(req_ready), 0);
            @(negedge clk);
        end
        req_line = 2'd3;
        #1;
        chk(!req_ready, "R10", "other line stalled", int'(req_ready), 0);
        req_valid = 1'b0;
        uack(0);
        expect_done(1, 0, "R10");
        send_req(2, 0, 0, 0);
        collect();
        chk(n_got == 1 && got_id[0] == 6, "R10", "state kept", n_got, 1);
        cleanup(0, 6, 0);
        expect_done(2, 0, "R10");

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule